// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block takes eight interrupt request lines and decides which one the processor should service next. Each line has its own mask bit. A request is latched into a pending-request register. The highest-ranked request that is not masked is offered on a pending output, together with its 3-bit level number. When the processor acknowledges, the level moves from the request register into an in-service register. From then on, requests of equal or lower rank are held back until an end-of-service command retires the top in-service level.

The ranking of the eight levels comes from a single pointer that marks the lowest-ranked level; the other levels follow it in circular order. Three schemes use this pointer. Fixed ordering pins the pointer so that level 0 ranks highest. Automatic rotation moves the pointer onto each level as its service ends. Specific rotation lets software place the pointer. The mode, the pointer and the mask can all be rewritten while requests are in flight. The mask, request and in-service registers are visible on output ports.

Top module: `prio_irq_resolver`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), irq_pend is 0, irq_idx is 0, mask_q, irr_q and isr_q are all 0x00, the mode is fixed and the lowest-ranked level is 7.
- R2: A request line that is high at a clock edge sets its bit in irr_q. That bit stays set after the line falls, and it is cleared by an accepted acknowledge of that level.
- R3: A level whose mask_q bit is 1 never appears on irq_idx while irq_pend is 1. A write with mask_we loads mask_wdata into mask_q at the next edge. Clearing the mask bit of a latched request makes it eligible.
- R4: In fixed mode (mode code 2'b00, and also the unused code 2'b11), level 0 ranks highest and rank falls step by step to level 7.
- R5: irq_pend is 1 only when an eligible request ranks strictly above every set bit of isr_q. A request of equal or lower rank than the top in-service level leaves irq_pend at 0.
- R6: An acknowledge while irq_pend is 1 sets the isr_q bit of irq_idx and clears that irr_q bit at the next edge. An acknowledge while irq_pend is 0 changes nothing.
- R7: An end-of-service command clears the highest-ranked set bit of isr_q under the current ordering. With isr_q empty it has no effect.
- R8: In automatic rotation mode (code 2'b01), the end-of-service command also makes the level it retires the lowest-ranked level.
- R9: In specific rotation mode (code 2'b10), a write with base_we makes base_wdata the lowest-ranked level. Levels base+1, base+2 and so on, modulo 8, rank from highest downwards. The end-of-service command does not move the pointer in this mode.
- R10: While irq_pend is 0, irq_idx keeps the value it last showed.
- R11: An acknowledge and an end-of-service command in the same cycle are both applied. A base write in the same cycle as an automatic rotation takes precedence over the rotation.
- R12: A mode write takes effect at the next edge and re-ranks requests that are already latched. Leaving a rotating mode keeps the stored pointer for later use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 8 | Request lines, bit n is level n |
| mask_we | input | 1 | Load mask register |
| mask_wdata | input | 8 | New mask value, 1 masks the level |
| mode_we | input | 1 | Load priority mode |
| mode_wdata | input | 2 | 00 fixed, 01 automatic rotation, 10 specific rotation |
| base_we | input | 1 | Load lowest-ranked level pointer |
| base_wdata | input | 3 | New lowest-ranked level |
| ack | input | 1 | Processor accepts the offered level |
| eos | input | 1 | End-of-service command |
| irq_pend | output | 1 | An eligible request outranks all in-service levels |
| irq_idx | output | 3 | Winning level, held while nothing is pending |
| mask_q | output | 8 | Current mask register |
| irr_q | output | 8 | Latched request register |
| isr_q | output | 8 | In-service register |

## Verification
Two pairs of functions can land on the same edge. The first is an acknowledge and an end-of-service command, which both write the in-service register. The bench provokes it by nesting level 1 on top of level 2 in service and raising ack and eos together. It then expects bit 2 to be retired and bit 1 to be set in that one cycle. The second pair is a base write and an automatic rotation. The bench issues eos and a base write of 2 on the same edge in rotation mode. It then judges which pointer won from the order in which latched levels 0 and 2 are offered.

// File: rtl/irq_res_pkg.sv
// Package irq_res_pkg
// Shared types for the rotating priority interrupt resolver.
// Assumes: the mode encoding below is the one software writes.
package irq_res_pkg;

    typedef enum logic [1:0] {
        MODE_FIXED = 2'b00,
        MODE_AUTO  = 2'b01,
        MODE_SPEC  = 2'b10,
        MODE_RSVD  = 2'b11
    } prio_mode_e;

endpackage

// File: rtl/irq_prio_pick.sv
// Module irq_prio_pick
// Finds the highest-ranked set bit of a vector under a circular ordering.
// The ordering is given by the level that ranks lowest. It reports that
// bit's level and its rank, where rank 0 is the highest.
// Assumes: low_lvl < N_LVL. Purely combinational.
module irq_prio_pick #(
    parameter int N_LVL = 8,
    parameter int IDX_W = $clog2(N_LVL)
) (
    input  logic [N_LVL-1:0] vec,
    input  logic [IDX_W-1:0] low_lvl,
    output logic             hit,
    output logic [IDX_W-1:0] lvl,
    output logic [IDX_W-1:0] rank
);

    // Walk ranks from lowest to highest so the highest-ranked hit is kept.
    always_comb begin
        hit  = 1'b0;
        lvl  = '0;
        rank = '0;
        for (int r = N_LVL - 1; r >= 0; r--) begin
            int lv;
            lv = (r + int'(low_lvl) + 1) % N_LVL;
            if (vec[lv]) begin
                hit  = 1'b1;
                lvl  = IDX_W'(lv);
                rank = IDX_W'(r);
            end
        end
    end

endmodule

// File: rtl/irq_req_reg.sv
// Module irq_req_reg
// Holds the latched request register and the mask register. Produces the
// eligible set: latched requests that are not masked.
// Assumes: clr_en is only raised for a level the resolver has offered.
module irq_req_reg #(
    parameter int N_LVL = 8,
    parameter int IDX_W = $clog2(N_LVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LVL-1:0] req,
    input  logic             mask_we,
    input  logic [N_LVL-1:0] mask_wdata,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N_LVL-1:0] irr_q,
    output logic [N_LVL-1:0] mask_q,
    output logic [N_LVL-1:0] eligible
);

    logic [N_LVL-1:0] clr_vec;

    // Decode the acknowledged level into a clear vector.
    always_comb begin
        clr_vec = '0;
        if (clr_en) clr_vec[clr_idx] = 1'b1;
    end

    // Latch incoming requests; an acknowledge clears its level.
    always_ff @(posedge clk) begin
        if (!rst_n) irr_q <= '0;
        else        irr_q <= (irr_q | req) & ~clr_vec;
    end

    // Load the mask on a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    assign eligible = irr_q & ~mask_q;

    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_q == $past(mask_wdata));

    // R2
    irr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !irr_q[$past(clr_idx)]);

    // R2
    irr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> (irr_q & $past(irr_q)) == $past(irr_q));

endmodule

// File: rtl/irq_svc_reg.sv
// Module irq_svc_reg
// Holds the in-service register, the priority mode and the lowest-rank
// pointer. Applies acknowledge and end-of-service updates and derives the
// effective lowest-ranked level for both priority pickers.
// Assumes: top_hit/top_lvl come from a picker fed with isr_q and low_eff.
module irq_svc_reg
    import irq_res_pkg::*;
#(
    parameter int N_LVL = 8,
    parameter int IDX_W = $clog2(N_LVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [1:0]       mode_wdata,
    input  logic             base_we,
    input  logic [IDX_W-1:0] base_wdata,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             eos,
    input  logic             top_hit,
    input  logic [IDX_W-1:0] top_lvl,
    output logic [N_LVL-1:0] isr_q,
    output logic [IDX_W-1:0] low_eff
);

    localparam logic [IDX_W-1:0] LOW_FIXED = IDX_W'(N_LVL - 1);

    prio_mode_e       mode_q;
    logic [IDX_W-1:0] lp_q;
    logic [N_LVL-1:0] set_vec;
    logic [N_LVL-1:0] eos_vec;
    logic             retire;

    assign retire = eos && top_hit;

    // Decode the acknowledged and the retired level into bit vectors.
    always_comb begin
        set_vec = '0;
        eos_vec = '0;
        if (set_en) set_vec[set_idx] = 1'b1;
        if (retire) eos_vec[top_lvl] = 1'b1;
    end

    // Update the in-service record: retire the top level, add the new one.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~eos_vec) | set_vec;
    end

    // Load the priority mode on a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_FIXED;
        else if (mode_we) mode_q <= prio_mode_e'(mode_wdata);
    end

    // Move the lowest-rank pointer: a base write wins over auto rotation.
    always_ff @(posedge clk) begin
        if (!rst_n)                           lp_q <= LOW_FIXED;
        else if (base_we)                     lp_q <= base_wdata;
        else if (retire && mode_q == MODE_AUTO) lp_q <= top_lvl;
    end

    // Fixed ordering ignores the stored pointer.
    always_comb begin
        unique case (mode_q)
            MODE_AUTO, MODE_SPEC: low_eff = lp_q;
            default:              low_eff = LOW_FIXED;
        endcase
    end

    // R8
    auto_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire && mode_q == MODE_AUTO && !base_we |=> lp_q == $past(top_lvl));

    // R11
    base_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |=> lp_q == $past(base_wdata));

    // R9
    spec_no_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == MODE_SPEC && !base_we |=> $stable(lp_q));

    // R6
    isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> isr_q[$past(set_idx)]);

    // R7
    isr_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire && !(set_en && set_idx == top_lvl) |=> !isr_q[$past(top_lvl)]);

    // R7
    isr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_en && !eos |=> $stable(isr_q));

    // R7
    retire_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eos_vec));

endmodule

// File: rtl/prio_irq_resolver.sv
// Module prio_irq_resolver
// Top of the interrupt resolver. It ranks eligible requests and in-service
// levels with two circular pickers, raises irq_pend when the best request
// outranks all in-service levels, and holds irq_idx while nothing pends.
// Assumes: ack is raised only in response to irq_pend; it is ignored
// otherwise.
module prio_irq_resolver
    import irq_res_pkg::*;
#(
    parameter int N_LVL = 8,
    parameter int IDX_W = $clog2(N_LVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LVL-1:0] irq_req,
    input  logic             mask_we,
    input  logic [N_LVL-1:0] mask_wdata,
    input  logic             mode_we,
    input  logic [1:0]       mode_wdata,
    input  logic             base_we,
    input  logic [IDX_W-1:0] base_wdata,
    input  logic             ack,
    input  logic             eos,
    output logic             irq_pend,
    output logic [IDX_W-1:0] irq_idx,
    output logic [N_LVL-1:0] mask_q,
    output logic [N_LVL-1:0] irr_q,
    output logic [N_LVL-1:0] isr_q
);

    logic [N_LVL-1:0] eligible;
    logic [IDX_W-1:0] low_eff;
    logic             req_hit, svc_hit;
    logic [IDX_W-1:0] req_lvl, svc_lvl;
    logic [IDX_W-1:0] req_rank, svc_rank;
    logic             pend_c;
    logic             ack_ok;
    logic [IDX_W-1:0] idx_hold_q;

    irq_req_reg #(.N_LVL(N_LVL), .IDX_W(IDX_W)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (irq_req),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .clr_en     (ack_ok),
        .clr_idx    (req_lvl),
        .irr_q      (irr_q),
        .mask_q     (mask_q),
        .eligible   (eligible)
    );

    irq_prio_pick #(.N_LVL(N_LVL), .IDX_W(IDX_W)) u_pick_req (
        .vec     (eligible),
        .low_lvl (low_eff),
        .hit     (req_hit),
        .lvl     (req_lvl),
        .rank    (req_rank)
    );

    irq_prio_pick #(.N_LVL(N_LVL), .IDX_W(IDX_W)) u_pick_svc (
        .vec     (isr_q),
        .low_lvl (low_eff),
        .hit     (svc_hit),
        .lvl     (svc_lvl),
        .rank    (svc_rank)
    );

    irq_svc_reg #(.N_LVL(N_LVL), .IDX_W(IDX_W)) u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .set_en     (ack_ok),
        .set_idx    (req_lvl),
        .eos        (eos),
        .top_hit    (svc_hit),
        .top_lvl    (svc_lvl),
        .isr_q      (isr_q),
        .low_eff    (low_eff)
    );

    // A request pends only if it strictly outranks the top in-service level.
    always_comb begin
        pend_c = req_hit && (!svc_hit || (req_rank < svc_rank));
    end

    assign ack_ok = ack && pend_c;

    // Remember the last offered level for the idle hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_hold_q <= '0;
        else if (pend_c) idx_hold_q <= req_lvl;
    end

    assign irq_pend = pend_c;
    assign irq_idx  = pend_c ? req_lvl : idx_hold_q;

    // R3
    masked_never_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> (!mask_q[irq_idx] && irr_q[irq_idx]));

    // R10
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pend |-> irq_idx == $past(irq_idx));

    // R6
    ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_pend && !eos) |=> $stable(isr_q));

    // R5
    pend_not_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> !isr_q[irq_idx]);

endmodule

// File: tb/test_prio_irq_resolver.sv
// Bench test_prio_irq_resolver
// Directed scenarios, one task each. Inputs change on the falling edge and
// outputs are sampled on the next falling edge.
module test_prio_irq_resolver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req = '0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       mode_we = 1'b0;
    logic [1:0] mode_wdata = '0;
    logic       base_we = 1'b0;
    logic [2:0] base_wdata = '0;
    logic       ack = 1'b0;
    logic       eos = 1'b0;
    logic       irq_pend;
    logic [2:0] irq_idx;
    logic [7:0] mask_q, irr_q, isr_q;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    prio_irq_resolver i_prio_irq_resolver (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .base_we(base_we), .base_wdata(base_wdata),
        .ack(ack), .eos(eos), .irq_pend(irq_pend), .irq_idx(irq_idx),
        .mask_q(mask_q), .irr_q(irr_q), .isr_q(isr_q)
    );

    task automatic chk(string rq, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic pulse_req(logic [7:0] v);
        irq_req = v; cyc(); irq_req = '0;
    endtask

    task automatic do_ack();
        ack = 1'b1; cyc(); ack = 1'b0;
    endtask

    task automatic do_eos();
        eos = 1'b1; cyc(); eos = 1'b0;
    endtask

    task automatic wr_mask(logic [7:0] v);
        mask_we = 1'b1; mask_wdata = v; cyc(); mask_we = 1'b0;
    endtask

    task automatic wr_mode(logic [1:0] v);
        mode_we = 1'b1; mode_wdata = v; cyc(); mode_we = 1'b0;
    endtask

    task automatic wr_base(logic [2:0] v);
        base_we = 1'b1; base_wdata = v; cyc(); base_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "pend", {7'b0, irq_pend}, 8'h00);
        chk("R1", "idx", {5'b0, irq_idx}, 8'h00);
        chk("R1", "mask", mask_q, 8'h00);
        chk("R1", "irr", irr_q, 8'h00);
        chk("R1", "isr", isr_q, 8'h00);
    endtask

    task automatic t_fixed();
        pulse_req(8'hA4);
        chk("R2", "irr latched", irr_q, 8'hA4);
        chk("R4", "pend", {7'b0, irq_pend}, 8'h01);
        chk("R4", "idx lowest level wins", {5'b0, irq_idx}, 8'h02);
        do_ack();
        chk("R6", "isr set", isr_q, 8'h04);
        chk("R2", "irr cleared", irr_q, 8'hA0);
        chk("R5", "lower held off", {7'b0, irq_pend}, 8'h00);
        chk("R10", "idx held", {5'b0, irq_idx}, 8'h02);
        do_eos();
        chk("R7", "isr retired", isr_q, 8'h00);
        chk("R4", "next idx", {5'b0, irq_idx}, 8'h05);
        do_ack();
        chk("R5", "7 below 5 held", {7'b0, irq_pend}, 8'h00);
        do_eos();
        chk("R4", "last idx", {5'b0, irq_idx}, 8'h07);
        do_ack(); do_eos();
        chk("R7", "isr empty", isr_q, 8'h00);
        do_eos();
        chk("R7", "eos on empty", isr_q, 8'h00);
        do_ack();
        chk("R6", "ack without pend ignored", isr_q, 8'h00);
        chk("R10", "idx still held", {5'b0, irq_idx}, 8'h07);
    endtask

    task automatic t_nest();
        pulse_req(8'h08);
        do_ack();
        chk("R6", "isr level 3", isr_q, 8'h08);
        pulse_req(8'h01 << 1);
        chk("R5", "higher request pends", {7'b0, irq_pend}, 8'h01);
        chk("R5", "higher idx", {5'b0, irq_idx}, 8'h01);
        do_ack();
        chk("R6", "nested isr", isr_q, 8'h0A);
        do_eos();
        chk("R7", "top retired first", isr_q, 8'h08);
        do_eos();
        chk("R7", "second retired", isr_q, 8'h00);
    endtask

    task automatic t_mask();
        wr_mask(8'h01);
        chk("R3", "mask readback", mask_q, 8'h01);
        pulse_req(8'h05);
        chk("R3", "masked skipped", {5'b0, irq_idx}, 8'h02);
        do_ack(); do_eos();
        chk("R3", "masked level not pending", {7'b0, irq_pend}, 8'h00);
        chk("R3", "masked kept in irr", irr_q, 8'h01);
        wr_mask(8'h00);
        chk("R3", "unmasked pends", {7'b0, irq_pend}, 8'h01);
        chk("R3", "unmasked idx", {5'b0, irq_idx}, 8'h00);
        do_ack(); do_eos();
    endtask

    task automatic t_auto();
        wr_mode(2'b01);
        pulse_req(8'h11);
        chk("R8", "first idx", {5'b0, irq_idx}, 8'h00);
        do_ack(); do_eos();
        chk("R8", "rotated idx", {5'b0, irq_idx}, 8'h04);
        pulse_req(8'h01);
        chk("R8", "0 now ranks last", {5'b0, irq_idx}, 8'h04);
        do_ack();
        chk("R5", "0 held behind 4", {7'b0, irq_pend}, 8'h00);
        do_eos();
        chk("R8", "0 after rotation", {5'b0, irq_idx}, 8'h00);
        do_ack(); do_eos();
    endtask

    task automatic t_specific();
        wr_mode(2'b10);
        wr_base(3'd3);
        pulse_req(8'h29);
        chk("R9", "5 ranks first", {5'b0, irq_idx}, 8'h05);
        do_ack();
        chk("R5", "held behind 5", {7'b0, irq_pend}, 8'h00);
        do_eos();
        chk("R9", "0 next", {5'b0, irq_idx}, 8'h00);
        do_ack(); do_eos();
        chk("R9", "3 last", {5'b0, irq_idx}, 8'h03);
        do_ack(); do_eos();
        pulse_req(8'h28);
        chk("R12", "specific order", {5'b0, irq_idx}, 8'h05);
        wr_mode(2'b00);
        chk("R12", "fixed re-rank", {5'b0, irq_idx}, 8'h03);
        do_ack(); do_eos(); do_ack(); do_eos();
        chk("R12", "drained", isr_q, 8'h00);
    endtask

    task automatic t_same_cycle();
        pulse_req(8'h04);
        do_ack();
        pulse_req(8'h02);
        chk("R11", "nest pends", {5'b0, irq_idx}, 8'h01);
        ack = 1'b1; eos = 1'b1; cyc(); ack = 1'b0; eos = 1'b0;
        chk("R11", "ack and eos together", isr_q, 8'h02);
        do_eos();
        wr_mode(2'b01);
        pulse_req(8'h01);
        do_ack();
        eos = 1'b1; base_we = 1'b1; base_wdata = 3'd2; cyc();
        eos = 1'b0; base_we = 1'b0;
        chk("R7", "retired with base write", isr_q, 8'h00);
        pulse_req(8'h05);
        chk("R11", "base beats rotation", {5'b0, irq_idx}, 8'h00);
        do_ack(); do_eos();
        chk("R8", "rotation after 0", {5'b0, irq_idx}, 8'h02);
        do_ack(); do_eos();
        wr_mode(2'b00);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) cyc();
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_fixed();
        t_nest();
        t_mask();
        t_auto();
        t_specific();
        t_same_cycle();
        summary();
        $finish;
    end

endmodule